// File: doc/BRIEF.md
# Burst ROM Nibble Read Controller

This block is a bus master for a boot ROM on chip-select 0 that may support nibble (burst) reads. An internal requester asks for a byte, a word, a longword or a 16-byte line at some address. The block splits the request into beats of the ROM's width, which is 8 or 16 bits. It drives the ROM address, an active-low chip select and an active-low read strobe. It packs the returned bytes big-endian into one result and signals the end with a single-cycle done pulse.

Each beat has two wait cycles, with chip select and read strobe low. The ROM data is sampled at the clock edge that ends the second wait cycle. An ordinary beat is preceded by one setup cycle. In that cycle the address is already valid but both strobes are high.

When burst mode is configured and the access takes more than one beat, only the first beat of each longword unit has a setup cycle. The strobes then stay low while the address steps to the next location, so each later beat is one cycle shorter. A line fill is issued as four separate longword units. Each unit after the first starts after an idle cycle followed by a fresh setup cycle.

Top module: `bootrom_burst_rd`

## Requirements
- R1: After reset, `rom_cs_n` and `rom_rd_n` are 1 and `busy` and `done` are 0.
- R2: Each beat holds `rom_cs_n` and `rom_rd_n` low for exactly two cycles, and ROM data is taken at the edge ending the second one. An 8-bit ROM (`rom_is16`=0, data on `rom_data[7:0]`) needs 1/2/4 beats for byte/word/longword. A 16-bit ROM (`rom_is16`=1) needs 1/1/2 beats. The `req_size` encoding is 0 byte, 1 word, 2 longword, 3 line.
- R3: With `burst_en`=1 and more than one beat per unit, the strobes stay low from the first to the last beat of a unit. Only the first beat has a setup cycle, so a unit costs 3 + 2·(beats−1) cycles.
- R4: Without burst (`burst_en`=0), every beat starts with a setup cycle in which both strobes are high. A unit then costs 3·beats cycles, and the strobes fall once per beat.
- R5: A single-beat access has the same timing whether or not `burst_en` is set. These are byte reads, and word reads from a 16-bit ROM.
- R6: The beat addresses start at the request address aligned down to its access size and step by the ROM width in bytes. A byte read from an 8-bit ROM uses the exact address. A byte read from a 16-bit ROM reads the even halfword and takes bits 15:8 for an even address and bits 7:0 for an odd one.
- R7: The result in `rsp_data` is big-endian and right-aligned. The first byte read is the most significant byte of the access, and the bits above the access size are 0.
- R8: A line request (`req_size`=3) reads four longwords from the address aligned to 16 bytes, first longword in bits 127:96. The units are separated by one idle cycle plus a setup cycle, so the total cost is 4·unit + 3 cycles.
- R9: `done` is high for exactly one cycle per request, in the cycle after the last data sample. `busy` is high from acceptance until then. A `req_valid` seen while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Read request, taken only when idle |
| req_addr | input | AW | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 16-byte line |
| rom_is16 | input | 1 | ROM width: 0 = 8 bits, 1 = 16 bits |
| burst_en | input | 1 | Chip-select 0 holds a burst-capable ROM |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: `rsp_data` is complete |
| rsp_data | output | 128 | Packed result, right-aligned |
| rom_addr | output | AW | ROM byte address |
| rom_cs_n | output | 1 | Chip select 0, active low |
| rom_rd_n | output | 1 | Read strobe, active low |
| rom_data | input | 16 | ROM data bus (8-bit ROM on bits 7:0) |

## Verification
The hardest condition to reach is the burst-specific step, where the address changes while chip select stays low. It is also the only condition in which a wrong sample edge still returns plausible data. The bench's ROM model therefore drives a distinct pattern whenever the read strobe is high. It also derives every byte from its own address, so a shift by one cycle or one address shows up in the packed result. The same addresses and sizes are replayed with `burst_en` on and off, and the cycle counts and strobe-fall counts are compared against the closed-form costs. A request is also pulsed in the middle of a line fill, to show that it leaves neither the result nor the number of done pulses changed.

// File: rtl/bootrom_burst_rd.sv
module bootrom_burst_rd #(
  parameter int AW    = 24,
  parameter int WAITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  input  logic          rom_is16,
  input  logic          burst_en,
  output logic          busy,
  output logic          done,
  output logic [127:0]  rsp_data,
  output logic [AW-1:0] rom_addr,
  output logic          rom_cs_n,
  output logic          rom_rd_n,
  input  logic [15:0]   rom_data
);
  localparam int WW = $clog2(WAITS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_WAIT, ST_GAP} st_t;

  st_t           st;
  logic [WW-1:0] wcnt;
  logic [1:0]    bcnt, ucnt;
  logic [2:0]    nb_q;
  logic          line_q, burst_q, is16_q, sh8_q, bsel_q;

  logic [2:0]    ub, nb_n;
  logic [AW-1:0] start_addr;
  logic [7:0]    beat_byte;
  logic          last_w, last_b, last_u, accept;

  assign ub     = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;
  assign nb_n   = rom_is16 ? ((ub == 3'd1) ? 3'd1 : (ub >> 1)) : ub;
  assign accept = (st == ST_IDLE) && req_valid;

  always_comb begin
    start_addr = req_addr;
    case (req_size)
      2'd0: if (rom_is16) start_addr[0] = 1'b0;
      2'd1: start_addr[0] = 1'b0;
      2'd2: start_addr[1:0] = 2'b00;
      default: start_addr[3:0] = 4'b0000;
    endcase
  end

  assign beat_byte = is16_q ? (bsel_q ? rom_data[7:0] : rom_data[15:8]) : rom_data[7:0];
  assign last_w    = wcnt == WW'(WAITS - 1);
  assign last_b    = {1'b0, bcnt} == (nb_q - 3'd1);
  assign last_u    = !line_q || (ucnt == 2'd3);

  assign busy     = st != ST_IDLE;
  assign rom_cs_n = st != ST_WAIT;
  assign rom_rd_n = st != ST_WAIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      wcnt     <= '0;
      bcnt     <= '0;
      ucnt     <= '0;
      nb_q     <= 3'd1;
      line_q   <= 1'b0;
      burst_q  <= 1'b0;
      is16_q   <= 1'b0;
      sh8_q    <= 1'b1;
      bsel_q   <= 1'b0;
      rsp_data <= '0;
      rom_addr <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          st       <= ST_SETUP;
          wcnt     <= '0;
          bcnt     <= '0;
          ucnt     <= '0;
          nb_q     <= nb_n;
          line_q   <= req_size == 2'd3;
          burst_q  <= burst_en && (nb_n > 3'd1);
          is16_q   <= rom_is16;
          sh8_q    <= !rom_is16 || (req_size == 2'd0);
          bsel_q   <= rom_is16 && (req_size == 2'd0) && req_addr[0];
          rsp_data <= '0;
          rom_addr <= start_addr;
        end
        ST_SETUP: begin
          st   <= ST_WAIT;
          wcnt <= '0;
        end
        ST_WAIT: begin
          if (!last_w) begin
            wcnt <= wcnt + WW'(1);
          end else begin
            wcnt     <= '0;
            rsp_data <= sh8_q ? {rsp_data[119:0], beat_byte} : {rsp_data[111:0], rom_data};
            if (!last_b) begin
              bcnt     <= bcnt + 2'd1;
              rom_addr <= rom_addr + (is16_q ? AW'(2) : AW'(1));
              if (!burst_q) st <= ST_SETUP;
            end else if (!last_u) begin
              bcnt     <= '0;
              ucnt     <= ucnt + 2'd1;
              rom_addr <= rom_addr + (is16_q ? AW'(2) : AW'(1));
              st       <= ST_GAP;
            end else begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
          end
        end
        default: st <= ST_SETUP;
      endcase
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st) == ST_WAIT);

  assert_strobe_after_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rom_rd_n)) |-> $past(st) == ST_SETUP);

  assert_addr_step_only_burst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && !$past(rom_cs_n) && rom_addr != $past(rom_addr)) |-> burst_q);

  assert_addr_hold_in_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT && wcnt != '0) |-> $stable(rom_addr));

  assert_ignore_busy_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !done) |-> $stable(nb_q) && $stable(line_q));
endmodule

// File: tb/sim_bootrom_burst_rd.sv
module sim_bootrom_burst_rd;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          rom_is16 = 1'b0;
  logic          burst_en = 1'b0;
  logic          busy, done, rom_cs_n, rom_rd_n;
  logic [127:0]  rsp_data;
  logic [AW-1:0] rom_addr;
  logic [15:0]   rom_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bootrom_burst_rd #(.AW(AW), .WAITS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .rom_is16(rom_is16), .burst_en(burst_en),
    .busy(busy), .done(done), .rsp_data(rsp_data), .rom_addr(rom_addr),
    .rom_cs_n(rom_cs_n), .rom_rd_n(rom_rd_n), .rom_data(rom_data));

  function automatic logic [7:0] fb(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  assign rom_data = rom_rd_n ? 16'hBAAD :
                    rom_is16 ? {fb({rom_addr[AW-1:1], 1'b0}), fb({rom_addr[AW-1:1], 1'b1})}
                             : {8'hEE, fb(rom_addr)};

  logic [127:0] q_data[$];
  int           q_lat[$];
  int           q_runs[$];
  string        q_tag[$];

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [AW-1:0] a, input logic [1:0] sz, input logic w16,
                        input logic be, input string tag);
    int ub, nb, nu, unit, nbytes;
    logic [AW-1:0] base;
    logic [127:0] d;
    ub = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    nb = w16 ? ((ub == 1) ? 1 : ub / 2) : ub;
    nu = (sz == 3) ? 4 : 1;
    nbytes = (sz == 3) ? 16 : ub;
    base = a & ~(AW'(nbytes) - AW'(1));
    d = '0;
    if (sz == 0) d = {120'd0, fb(a)};
    else for (int i = 0; i < nbytes; i++) d = {d[119:0], fb(base + AW'(i))};
    unit = 3 + (nb - 1) * ((be && nb > 1) ? 2 : 3);
    q_data.push_back(d);
    q_lat.push_back(nu * unit + (nu - 1));
    q_runs.push_back((be && nb > 1) ? nu : nu * nb);
    q_tag.push_back(tag);
    while (busy) @(negedge clk);
    req_addr = a; req_size = sz; rom_is16 = w16; burst_en = be; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  int   lat_cnt = 0, run_cnt = 0;
  logic prev_cs = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) lat_cnt++;
      if (!rom_cs_n && prev_cs) run_cnt++;
      prev_cs = rom_cs_n;
      if (done) begin
        if (q_data.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9: actual extra done expected none");
        end else begin
          string t;
          t = q_tag.pop_front();
          chk({t, " data R7"}, rsp_data, q_data.pop_front());
          chk({t, " cycles R3/R4"}, 128'(lat_cnt), 128'(q_lat.pop_front()));
          chk({t, " strobe falls R2"}, 128'(run_cnt), 128'(q_runs.pop_front()));
        end
        lat_cnt = 0; run_cnt = 0;
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs_n", 128'(rom_cs_n), 128'd1);
    chk("R1 rd_n", 128'(rom_rd_n), 128'd1);
    chk("R1 busy", 128'(busy), 128'd0);
    chk("R1 done", 128'(done), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    do_req(24'h000123, 2'd2, 1'b0, 1'b1, "R3 long8 burst");
    do_req(24'h000123, 2'd2, 1'b0, 1'b0, "R4 long8 plain");
    do_req(24'h000455, 2'd1, 1'b0, 1'b1, "R6 word8 burst");
    do_req(24'h000455, 2'd1, 1'b0, 1'b0, "R2 word8 plain");
    do_req(24'h000A07, 2'd0, 1'b0, 1'b1, "R5 byte8 burst");
    do_req(24'h000A07, 2'd0, 1'b0, 1'b0, "R5 byte8 plain");
    do_req(24'h000B10, 2'd0, 1'b1, 1'b1, "R6 byte16 even");
    do_req(24'h000B11, 2'd0, 1'b1, 1'b0, "R6 byte16 odd");
    do_req(24'h000C33, 2'd1, 1'b1, 1'b1, "R5 word16 burst");
    do_req(24'h000D36, 2'd2, 1'b1, 1'b1, "R3 long16 burst");
    do_req(24'h000D36, 2'd2, 1'b1, 1'b0, "R4 long16 plain");
    do_req(24'h00F2E9, 2'd3, 1'b0, 1'b1, "R8 line8 burst");
    do_req(24'h00F2E9, 2'd3, 1'b1, 1'b1, "R8 line16 burst");
    do_req(24'h001357, 2'd3, 1'b1, 1'b0, "R8 line16 plain");
    repeat (6) @(negedge clk);
    req_addr = 24'h0FFFF0; req_size = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy || q_data.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    chk("R9 queue drained", 128'(q_data.size()), 128'd0);
    chk("R9 idle strobes", 128'({rom_cs_n, rom_rd_n, busy}), 128'b110);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule